// File: doc/BRIEF.md
# PCM Multiframe Sync Generator

This block tracks the position of a transmit PCM stream and marks the start of each PCM multiframe with a single-clock sync pulse. A chain of three counters follows the stream. The bit counter runs within a frame, the frame counter runs within a multiframe, and the multiframe counter runs within a fixed period made of a programmed number of multiframes. The pulse tells the system where bit 0 of frame 0 of its transmit data must be presented so that the data maps synchronously onto the downstream framing. The block never looks at the data itself.

An external sync input realigns the counter chain. The input is captured on the falling edge of the PCM clock, and every output changes on the rising edge. Two programmed offsets move the pulse away from the external reference: a whole number of bit periods and a whole number of frames. When no external sync arrives, the chain free-runs and keeps producing pulses at the programmed multiframe rate. Length settings written while the chain free-runs are held back until the next multiframe start. An external sync applies them at once.

Top module: `pcm_msync_gen`

## Requirements
- R1: While `rst` is high, and in the first clock period after it is released, `bit_pos`, `frame_pos` and `mf_pos` are 0 and `mf_sync` is 1. The settings present during reset are taken as the active settings.
- R2: With no realignment, `bit_pos` rises by one per clock from 0 to `frame_len`-1 and then returns to 0.
- R3: `frame_pos` rises by one each time `bit_pos` wraps, running from 0 to `mf_len`-1, and returns to 0 when both counters wrap together.
- R4: `mf_pos` rises by one at each multiframe start and wraps to 0 when it reaches `mf_per_period`. Its range is 0 to `mf_per_period`-1.
- R5: `mf_sync` is 1 exactly in the clock periods where `bit_pos` is 0 and `frame_pos` is 0. When `frame_len`×`mf_len` is greater than 1, each pulse lasts one clock period.
- R6: `ext_sync` is sampled only on the falling clock edge. With both delays at 0, `mf_sync` is 1 in the clock period that follows the first rising edge after a falling edge that saw `ext_sync` high. A high level on `ext_sync` that does not span a falling edge has no effect.
- R7: With bit delay D and frame delay F, the first pulse after a realignment comes D + F×`frame_len` clock periods after the zero-delay position of R6. `mf_pos` is 0 in that period.
- R8: With `mf_len` = 1, `mf_sync` marks bit 0 of every frame, once every `frame_len` clocks.
- R9: A change to any setting made while the chain free-runs takes effect at the next multiframe start. A realignment applies the current settings immediately.
- R10: A length setting of 0 acts as 1. A bit delay of `frame_len` or more acts as `frame_len`-1. A frame delay of `mf_len` or more acts as `mf_len`-1.
- R11: With no external sync, pulses repeat every `frame_len`×`mf_len` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_sync | input | 1 | External alignment reference, sampled on the falling edge |
| frame_len | input | 9 | Bit periods per PCM frame |
| mf_len | input | 6 | Frames per multiframe |
| mf_per_period | input | 6 | Multiframes per timing period |
| bit_delay | input | 9 | Bit periods between the reference and the pulse |
| frame_delay | input | 6 | Whole frames between the reference and the pulse |
| mf_sync | output | 1 | Multiframe start pulse, one clock wide |
| bit_pos | output | 9 | Current bit position within the frame |
| frame_pos | output | 6 | Current frame position within the multiframe |
| mf_pos | output | 6 | Current multiframe position within the period |

## Verification
Every clock, the assertions check that the pulse coincides with position bit 0 of frame 0, that each counter stays below its active length, and that the bit and frame counters step by one between wraps. They also check that the active settings change only on a multiframe start or a realignment, and that no active length is zero. The bench scenarios cover what no single-cycle property can show. These are the exact distance from a sampled reference to the delayed pulse under several length and delay combinations, with clamped and zero settings among them. They also include rejection of a reference level that misses the falling edge, and the deferral of a length change to the following multiframe.

// File: rtl/pcm_msync_pkg.sv
package pcm_msync_pkg;

    localparam int BIT_W = 9;
    localparam int FRM_W = 6;
    localparam int MF_W  = 6;

    typedef logic [BIT_W-1:0] bit_idx_t;
    typedef logic [FRM_W-1:0] frm_idx_t;
    typedef logic [MF_W-1:0]  mf_idx_t;

    typedef struct packed {
        bit_idx_t frame_len;
        frm_idx_t mf_len;
        mf_idx_t  mf_per;
        bit_idx_t bit_dly;
        frm_idx_t frm_dly;
    } timing_cfg_t;

    typedef struct packed {
        bit_idx_t bit_n;
        frm_idx_t frm_n;
        mf_idx_t  mf_n;
    } stream_pos_t;

    // Zero lengths act as one; delays saturate at length minus one.
    function automatic timing_cfg_t normalize_cfg(timing_cfg_t raw);
        timing_cfg_t c;
        c = raw;
        if (c.frame_len == '0) c.frame_len = bit_idx_t'(1);
        if (c.mf_len == '0)    c.mf_len    = frm_idx_t'(1);
        if (c.mf_per == '0)    c.mf_per    = mf_idx_t'(1);
        if (c.bit_dly >= c.frame_len) c.bit_dly = c.frame_len - bit_idx_t'(1);
        if (c.frm_dly >= c.mf_len)    c.frm_dly = c.mf_len - frm_idx_t'(1);
        return c;
    endfunction

    // Position to load on a realignment so that the chain reaches
    // bit 0 / frame 0 exactly bit_dly + frm_dly*frame_len clocks later.
    function automatic stream_pos_t realign_pos(timing_cfg_t c);
        stream_pos_t p;
        if (c.bit_dly == '0) begin
            p.bit_n = '0;
            p.frm_n = (c.frm_dly == '0) ? '0 : c.mf_len - c.frm_dly;
        end else begin
            p.bit_n = c.frame_len - c.bit_dly;
            p.frm_n = c.mf_len - frm_idx_t'(1) - c.frm_dly;
        end
        p.mf_n = (c.bit_dly == '0 && c.frm_dly == '0) ? '0 : c.mf_per - mf_idx_t'(1);
        return p;
    endfunction

    function automatic logic at_origin(stream_pos_t p);
        return (p.bit_n == '0) && (p.frm_n == '0);
    endfunction

endpackage

// File: rtl/msync_edge_sample.sv
module msync_edge_sample (
    input  logic clk,
    input  logic rst,
    input  logic ext_sync,
    output logic sync_seen
);
    // Reference is captured on the falling edge, half a period ahead of
    // the rising edge that acts on it.
    always_ff @(negedge clk) begin
        if (rst) sync_seen <= 1'b0;
        else     sync_seen <= ext_sync;
    end
endmodule

// File: rtl/msync_cfg_hold.sv
module msync_cfg_hold
    import pcm_msync_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  timing_cfg_t raw_cfg,
    output timing_cfg_t live_norm,
    output timing_cfg_t held_cfg
);
    assign live_norm = normalize_cfg(raw_cfg);

    always_ff @(posedge clk) begin
        if (rst || take) held_cfg <= live_norm;
    end

    // R9: active settings move only on a multiframe start or realignment
    a_r9_held_stable: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(held_cfg));

    // R10: no active length is ever zero
    a_r10_held_nonzero: assert property (@(posedge clk) disable iff (rst)
        (held_cfg.frame_len != '0) && (held_cfg.mf_len != '0) && (held_cfg.mf_per != '0));
endmodule

// File: rtl/msync_count_chain.sv
module msync_count_chain
    import pcm_msync_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  timing_cfg_t live_norm,
    input  timing_cfg_t held_cfg,
    output stream_pos_t pos,
    output logic        mf_sync,
    output logic        boundary
);
    stream_pos_t nxt;
    logic        nxt_pulse;
    logic        bit_last;
    logic        frm_last;
    mf_idx_t     mf_inc;

    assign bit_last = (pos.bit_n == held_cfg.frame_len - bit_idx_t'(1));
    assign frm_last = (pos.frm_n == held_cfg.mf_len - frm_idx_t'(1));
    assign boundary = bit_last && frm_last;
    assign mf_inc   = pos.mf_n + mf_idx_t'(1);

    always_comb begin
        nxt       = pos;
        nxt_pulse = 1'b0;
        if (load) begin
            nxt       = realign_pos(live_norm);
            nxt_pulse = at_origin(nxt);
        end else if (boundary) begin
            nxt.bit_n = '0;
            nxt.frm_n = '0;
            nxt.mf_n  = (mf_inc >= live_norm.mf_per) ? '0 : mf_inc;
            nxt_pulse = 1'b1;
        end else if (bit_last) begin
            nxt.bit_n = '0;
            nxt.frm_n = pos.frm_n + frm_idx_t'(1);
        end else begin
            nxt.bit_n = pos.bit_n + bit_idx_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            mf_sync <= 1'b1;
        end else begin
            pos     <= nxt;
            mf_sync <= nxt_pulse;
        end
    end

    // R5: pulse exactly at bit 0 of frame 0
    a_r5_pulse_at_origin: assert property (@(posedge clk) disable iff (rst)
        mf_sync == at_origin(pos));

    // R2: bit position stays inside the frame and steps by one
    a_r2_bit_in_range: assert property (@(posedge clk) disable iff (rst)
        pos.bit_n < held_cfg.frame_len);
    a_r2_bit_steps: assert property (@(posedge clk) disable iff (rst)
        (!load && !bit_last) |=> pos.bit_n == $past(pos.bit_n) + bit_idx_t'(1));

    // R3: frame position stays inside the multiframe and steps on bit wrap
    a_r3_frame_in_range: assert property (@(posedge clk) disable iff (rst)
        pos.frm_n < held_cfg.mf_len);
    a_r3_frame_steps: assert property (@(posedge clk) disable iff (rst)
        (!load && bit_last && !frm_last) |=>
            (pos.frm_n == $past(pos.frm_n) + frm_idx_t'(1)) && (pos.bit_n == '0));

    // R4: multiframe position stays inside the period
    a_r4_mf_in_range: assert property (@(posedge clk) disable iff (rst)
        pos.mf_n < held_cfg.mf_per);
endmodule

// File: rtl/pcm_msync_gen.sv
module pcm_msync_gen
    import pcm_msync_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_sync,
    input  logic [BIT_W-1:0] frame_len,
    input  logic [FRM_W-1:0] mf_len,
    input  logic [MF_W-1:0]  mf_per_period,
    input  logic [BIT_W-1:0] bit_delay,
    input  logic [FRM_W-1:0] frame_delay,
    output logic             mf_sync,
    output logic [BIT_W-1:0] bit_pos,
    output logic [FRM_W-1:0] frame_pos,
    output logic [MF_W-1:0]  mf_pos
);
    timing_cfg_t raw_cfg;
    timing_cfg_t live_norm;
    timing_cfg_t held_cfg;
    stream_pos_t pos;
    logic        sync_seen;
    logic        boundary;

    assign raw_cfg = '{frame_len: frame_len, mf_len: mf_len, mf_per: mf_per_period,
                       bit_dly: bit_delay, frm_dly: frame_delay};

    msync_edge_sample u_sample (
        .clk       (clk),
        .rst       (rst),
        .ext_sync  (ext_sync),
        .sync_seen (sync_seen)
    );

    msync_cfg_hold u_cfg (
        .clk       (clk),
        .rst       (rst),
        .take      (sync_seen || boundary),
        .raw_cfg   (raw_cfg),
        .live_norm (live_norm),
        .held_cfg  (held_cfg)
    );

    msync_count_chain u_chain (
        .clk       (clk),
        .rst       (rst),
        .load      (sync_seen),
        .live_norm (live_norm),
        .held_cfg  (held_cfg),
        .pos       (pos),
        .mf_sync   (mf_sync),
        .boundary  (boundary)
    );

    assign bit_pos   = pos.bit_n;
    assign frame_pos = pos.frm_n;
    assign mf_pos    = pos.mf_n;
endmodule

// File: tb/sim_pcm_msync_gen.sv
module sim_pcm_msync_gen;
    import pcm_msync_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ext_sync = 1'b0;
    logic [BIT_W-1:0] frame_len = '0;
    logic [FRM_W-1:0] mf_len = '0;
    logic [MF_W-1:0]  mf_per_period = '0;
    logic [BIT_W-1:0] bit_delay = '0;
    logic [FRM_W-1:0] frame_delay = '0;
    logic             mf_sync;
    logic [BIT_W-1:0] bit_pos;
    logic [FRM_W-1:0] frame_pos;
    logic [MF_W-1:0]  mf_pos;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pcm_msync_gen u0 (
        .clk(clk), .rst(rst), .ext_sync(ext_sync),
        .frame_len(frame_len), .mf_len(mf_len), .mf_per_period(mf_per_period),
        .bit_delay(bit_delay), .frame_delay(frame_delay),
        .mf_sync(mf_sync), .bit_pos(bit_pos), .frame_pos(frame_pos), .mf_pos(mf_pos)
    );

    // columns: L, M, Z, bit delay, frame delay, pulse offset, period, mf at 2nd pulse
    localparam int NV = 7;
    localparam int VECS [NV][8] = '{
        '{ 8, 4, 3, 0, 0,  0, 32, 1},
        '{ 8, 4, 3, 3, 0,  3, 32, 1},
        '{ 8, 4, 3, 0, 2, 16, 32, 1},
        '{10, 3, 2, 7, 1, 17, 30, 1},
        '{ 5, 1, 4, 2, 0,  2,  5, 1},
        '{ 6, 2, 2, 9, 5, 11, 12, 1},
        '{ 0, 3, 1, 0, 1,  1,  3, 0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int l, input int m, input int z, input int d, input int f);
        frame_len     = BIT_W'(l);
        mf_len        = FRM_W'(m);
        mf_per_period = MF_W'(z);
        bit_delay     = BIT_W'(d);
        frame_delay   = FRM_W'(f);
    endtask

    // advance one clock; drop any reference level; sample 7 ns after the edge
    task automatic step();
        @(posedge clk);
        #1 ext_sync = 1'b0;
        #6;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #6;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // ---- vector table: realign with delays, check pulse timing ----
        set_cfg(4, 2, 3, 0, 0);
        do_reset();
        for (int i = 0; i < NV; i++) begin
            string tag;
            int    off;
            int    per;
            tag = (i == 0) ? "R6" : (i == 4) ? "R8" : (i >= 5) ? "R10" : "R7";
            off = VECS[i][5];
            per = VECS[i][6];
            set_cfg(VECS[i][0], VECS[i][1], VECS[i][2], VECS[i][3], VECS[i][4]);
            @(posedge clk);
            #1 ext_sync = 1'b1;
            step();
            for (int c = 0; c <= off + per; c++) begin
                if (c == off + per)
                    chk(mf_sync == 1'b1, "R9 R11 period", int'(mf_sync), 1);
                else
                    chk(mf_sync == (c == off), {tag, " R5 pulse"}, int'(mf_sync), int'(c == off));
                if (c == off) begin
                    chk(bit_pos == '0, {tag, " bit at pulse"}, int'(bit_pos), 0);
                    chk(frame_pos == '0, {tag, " frame at pulse"}, int'(frame_pos), 0);
                    chk(mf_pos == '0, "R7 mf at pulse", int'(mf_pos), 0);
                end
                if (c == off + 1 && VECS[i][0] > 1)
                    chk(bit_pos == BIT_W'(1), "R2 bit after pulse", int'(bit_pos), 1);
                if (c == off + per)
                    chk(int'(mf_pos) == VECS[i][7], "R4 mf second pulse", int'(mf_pos), VECS[i][7]);
                if (c < off + per) step();
            end
        end

        // ---- reset state and free run, with a reference glitch ----
        set_cfg(4, 2, 3, 0, 0);
        do_reset();
        for (int c = 0; c <= 24; c++) begin
            string t2;
            t2 = (c == 0) ? "R1" : (c > 10) ? "R6 glitch R2" : "R2";
            chk(int'(bit_pos) == c % 4, t2, int'(bit_pos), c % 4);
            chk(int'(frame_pos) == (c / 4) % 2, (c == 0) ? "R1" : "R3", int'(frame_pos), (c / 4) % 2);
            chk(int'(mf_pos) == (c / 8) % 3, (c == 0) ? "R1" : "R4", int'(mf_pos), (c / 8) % 3);
            chk(mf_sync == (c % 8 == 0), (c == 0) ? "R1" : "R11", int'(mf_sync), int'(c % 8 == 0));
            if (c == 10) ext_sync = 1'b1;  // high only after the falling edge
            if (c < 24) step();
        end

        // ---- length change deferred to next multiframe ----
        set_cfg(4, 2, 3, 0, 0);
        do_reset();
        for (int c = 0; c <= 22; c++) begin
            int eb;
            eb = (c < 8) ? c % 4 : (c - 8) % 6;
            chk(int'(bit_pos) == eb, "R9 bit", int'(bit_pos), eb);
            chk(mf_sync == (c == 0 || c == 8 || c == 20), "R9 pulse", int'(mf_sync),
                int'(c == 0 || c == 8 || c == 20));
            if (c == 20) chk(int'(mf_pos) == 2, "R9 R4 mf", int'(mf_pos), 2);
            if (c == 3) frame_len = BIT_W'(6);
            if (c < 22) step();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule